// File: doc/BRIEF.md
# Extended-Page Opcode Classifier

This block decodes the byte that follows the extended-page escape prefix (0xED) of an 8-bit microprocessor instruction set. It is purely combinational. It turns that byte into an operation class and a small set of attributes that a later execution stage needs:

- how many operand bytes follow;
- which register a port transfer names;
- whether a port input keeps only its flags;
- whether a port output sends a constant zero;
- which register pair a 16-bit operation selects;
- the interrupt mode chosen;
- the direction of a nibble rotate;
- whether the operation is tied to HL whatever index prefix came before.

Encodings that the instruction set does not document are folded into the same class as the documented operation they copy. This covers the spare negate slots, the spare return and mode-select slots, and the second absolute-load encodings of HL. The inert areas of the page are classed as no-operation: the first and last quarters, the unused rows of the third quarter, and the two empty slots in the second quarter. The block-transfer and block-search rows are flagged as one class and are not expanded further.

Class codes on `op_class`:

| Code | Class |
|---|---|
| 0 | NOP |
| 1 | NEG |
| 2 | RETN |
| 3 | RETI |
| 4 | IMODE |
| 5 | PORT_IN |
| 6 | PORT_OUT |
| 7 | SBC16 |
| 8 | ADC16 |
| 9 | ABS_ST |
| 10 | ABS_LD |
| 11 | NIB_ROT |
| 12 | IR_XFER |
| 13 | BLOCK |

Top module: `edc_classifier`

## Requirements
- R1: Opcodes 0x00-0x3F and 0xC0-0xFF give class NOP (0), with every attribute output zero.
- R2: Opcodes 0x44, 0x4C, 0x54, 0x5C, 0x64, 0x6C, 0x74 and 0x7C all give class NEG (1).
- R3: In 0x40-0x7F, low bits 2:0 = 000 give class PORT_IN (5) with `port_reg` = opcode bits 5:3 (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 none, 7 A). `in_flags_only` is 1 only for 0x70.
- R4: In 0x40-0x7F, low bits = 001 give class PORT_OUT (6) with `port_reg` = bits 5:3. `out_zero` is 1 only for 0x71.
- R5: In 0x40-0x7F, low bits = 010 give SBC16 (7) when bit 3 is 0 and ADC16 (8) when bit 3 is 1. For both, `pair_sel` = bits 5:4 (0 BC, 1 DE, 2 HL, 3 SP) and `hl_fixed` = 1.
- R6: In 0x40-0x7F, low bits = 011 give ABS_ST (9) when bit 3 is 0 and ABS_LD (10) when bit 3 is 1. For both, `operand_bytes` = 2 and `pair_sel` = bits 5:4, so 0x63 and 0x6B select HL. Every other opcode gives `operand_bytes` = 0.
- R7: In 0x40-0x7F, low bits = 101 give RETI (3) when bit 3 is 1 and RETN (2) when bit 3 is 0.
- R8: In 0x40-0x7F, low bits = 110 give IMODE (4). `im_mode` comes from bits 4:3: 00 or 01 give 0, 10 gives 1, 11 gives 2.
- R9: 0x47, 0x4F, 0x57 and 0x5F give IR_XFER (12). 0x67 and 0x6F give NIB_ROT (11) with `hl_fixed` = 1 and `nib_left` = 1 only for 0x6F. 0x77 and 0x7F give NOP with all attributes zero.
- R10: Opcodes 0xA0-0xA3, 0xA8-0xAB, 0xB0-0xB3 and 0xB8-0xBB give BLOCK (13). Every other opcode in 0x80-0xBF gives NOP with all attributes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Byte following the extended-page prefix |
| op_class | output | 4 | Operation class code |
| operand_bytes | output | 2 | Count of operand bytes that follow |
| port_reg | output | 3 | Register field of a port transfer |
| in_flags_only | output | 1 | Port input updates flags and discards the data |
| out_zero | output | 1 | Port output drives constant zero |
| pair_sel | output | 2 | Register pair of 16-bit arithmetic or absolute load/store |
| im_mode | output | 2 | Interrupt mode selected |
| nib_left | output | 1 | Nibble rotate is leftward |
| hl_fixed | output | 1 | Operation always acts on HL, regardless of any index prefix |

## Verification
The block holds no state, so any decode fault shows on the ports in the same cycle the opcode is applied. Such a fault would be a wrong row or column split, a swapped bit-3 test, or an alias left out. A misplaced boundary would flip the class of one column, for example a return or mode slot landing in NOP, or a block row leaking into the dead part of the third quarter. Sweeping every one of the 256 codes against a model written from the opcode lists exposes each such error at the exact opcode where it occurs. Directed codes before the sweep hit the aliases, the register-less port forms and the quarter edges.

// File: rtl/edc_pkg.sv
package edc_pkg;

    localparam int OPC_W  = 8;
    localparam int CLS_W  = 4;
    localparam int REG_W  = 3;
    localparam int PAIR_W = 2;
    localparam int IM_W   = 2;
    localparam int OPB_W  = 2;

    // Register field value meaning "no register"
    localparam logic [REG_W-1:0] REG_NONE = 3'd6;
    // Operand byte count for an absolute address
    localparam logic [OPB_W-1:0] ADDR_BYTES = 2'd2;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP      = 4'd0,
        CLS_NEG      = 4'd1,
        CLS_RETN     = 4'd2,
        CLS_RETI     = 4'd3,
        CLS_IMODE    = 4'd4,
        CLS_PORT_IN  = 4'd5,
        CLS_PORT_OUT = 4'd6,
        CLS_SBC16    = 4'd7,
        CLS_ADC16    = 4'd8,
        CLS_ABS_ST   = 4'd9,
        CLS_ABS_LD   = 4'd10,
        CLS_NIB_ROT  = 4'd11,
        CLS_IR_XFER  = 4'd12,
        CLS_BLOCK    = 4'd13
    } edc_class_e;

    typedef struct packed {
        edc_class_e         cls;
        logic [OPB_W-1:0]   opnd_bytes;
        logic [REG_W-1:0]   port_reg;
        logic               in_flags_only;
        logic               out_zero;
        logic [PAIR_W-1:0]  pair_sel;
        logic [IM_W-1:0]    im_mode;
        logic               nib_left;
        logic               hl_fixed;
    } edc_attr_t;

    // Interrupt mode from the two low bits of the row field
    function automatic logic [IM_W-1:0] im_from_row(input logic [1:0] row_lo);
        case (row_lo)
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/edc_main_quarter.sv
// Decoder for the 0x40-0x7F quarter; only the six low opcode bits matter here.
module edc_main_quarter
    import edc_pkg::*;
(
    input  logic [5:0] low6,
    output edc_attr_t  attr
);
    logic [2:0] col;
    logic [2:0] row;

    assign col = low6[2:0];
    assign row = low6[5:3];

    always_comb begin
        attr = '0;
        unique case (col)
            3'd0: begin
                attr.cls           = CLS_PORT_IN;
                attr.port_reg      = row;
                attr.in_flags_only = (row == REG_NONE);
            end
            3'd1: begin
                attr.cls      = CLS_PORT_OUT;
                attr.port_reg = row;
                attr.out_zero = (row == REG_NONE);
            end
            3'd2: begin
                attr.cls      = row[0] ? CLS_ADC16 : CLS_SBC16;
                attr.pair_sel = row[2:1];
                attr.hl_fixed = 1'b1;
            end
            3'd3: begin
                attr.cls        = row[0] ? CLS_ABS_LD : CLS_ABS_ST;
                attr.pair_sel   = row[2:1];
                attr.opnd_bytes = ADDR_BYTES;
            end
            3'd4: attr.cls = CLS_NEG;
            3'd5: attr.cls = row[0] ? CLS_RETI : CLS_RETN;
            3'd6: begin
                attr.cls     = CLS_IMODE;
                attr.im_mode = im_from_row(row[1:0]);
            end
            default: begin
                if (!row[2]) begin
                    attr.cls = CLS_IR_XFER;
                end else if (!row[1]) begin
                    attr.cls      = CLS_NIB_ROT;
                    attr.nib_left = row[0];
                    attr.hl_fixed = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        // R7
        ret_split_chk: assert (!(attr.cls == CLS_RETI) || (col == 3'd5 && row[0]));
        // R3
        flags_in_chk: assert (!attr.in_flags_only || (attr.cls == CLS_PORT_IN && attr.port_reg == REG_NONE));
    end

endmodule

// File: rtl/edc_block_row.sv
// Flags the block-transfer/search rows inside the 0x80-0xBF quarter.
module edc_block_row (
    input  logic       in_quarter,
    input  logic       row_hi,
    input  logic       col_hi,
    output logic       is_block
);
    // Rows 0xA0-0xBF with opcode bit 2 clear carry block operations
    assign is_block = in_quarter && row_hi && !col_hi;
endmodule

// File: rtl/edc_classifier.sv
module edc_classifier
    import edc_pkg::*;
(
    input  logic [7:0] opcode,
    output logic [3:0] op_class,
    output logic [1:0] operand_bytes,
    output logic [2:0] port_reg,
    output logic       in_flags_only,
    output logic       out_zero,
    output logic [1:0] pair_sel,
    output logic [1:0] im_mode,
    output logic       nib_left,
    output logic       hl_fixed
);
    localparam logic [1:0] Q_MAIN  = 2'b01;
    localparam logic [1:0] Q_BLOCK = 2'b10;

    logic [1:0] quarter;
    edc_attr_t  main_attr;
    edc_attr_t  sel;
    logic       blk_hit;

    assign quarter = opcode[OPC_W-1 -: 2];

    edc_main_quarter u_main (
        .low6 (opcode[5:0]),
        .attr (main_attr)
    );

    edc_block_row u_blk (
        .in_quarter (quarter == Q_BLOCK),
        .row_hi     (opcode[5]),
        .col_hi     (opcode[2]),
        .is_block   (blk_hit)
    );

    always_comb begin
        sel = '0;
        if (quarter == Q_MAIN) begin
            sel = main_attr;
        end else if (blk_hit) begin
            sel.cls = CLS_BLOCK;
        end
    end

    assign op_class      = sel.cls;
    assign operand_bytes = sel.opnd_bytes;
    assign port_reg      = sel.port_reg;
    assign in_flags_only = sel.in_flags_only;
    assign out_zero      = sel.out_zero;
    assign pair_sel      = sel.pair_sel;
    assign im_mode       = sel.im_mode;
    assign nib_left      = sel.nib_left;
    assign hl_fixed      = sel.hl_fixed;

    always_comb begin
        // R1
        dead_quarter_chk: assert (opcode[7] == opcode[6] ? (op_class == CLS_NOP && sel == '0) : 1'b1);
        // R6
        opnd_bytes_chk: assert (operand_bytes == 2'd0 || op_class == CLS_ABS_ST || op_class == CLS_ABS_LD);
        // R10
        block_place_chk: assert (op_class != CLS_BLOCK || (opcode[7:5] == 3'b101 && !opcode[2]));
        // R5
        hl_tie_chk: assert (!hl_fixed || op_class == CLS_SBC16 || op_class == CLS_ADC16 || op_class == CLS_NIB_ROT);
        // R4
        zero_out_chk: assert (!out_zero || opcode == 8'h71);
    end

endmodule

// File: tb/tb_edc_classifier.sv
module tb_edc_classifier;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic [7:0] opcode;
    logic [3:0] op_class;
    logic [1:0] operand_bytes;
    logic [2:0] port_reg;
    logic       in_flags_only;
    logic       out_zero;
    logic [1:0] pair_sel;
    logic [1:0] im_mode;
    logic       nib_left;
    logic       hl_fixed;

    typedef struct {
        logic [7:0]  op;
        logic [16:0] exp;
    } item_t;

    item_t q[$];
    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    edc_classifier dut (
        .opcode        (opcode),
        .op_class      (op_class),
        .operand_bytes (operand_bytes),
        .port_reg      (port_reg),
        .in_flags_only (in_flags_only),
        .out_zero      (out_zero),
        .pair_sel      (pair_sel),
        .im_mode       (im_mode),
        .nib_left      (nib_left),
        .hl_fixed      (hl_fixed)
    );

    // Reference built from the opcode lists in the requirements.
    // Packing: {class, operand_bytes, port_reg, in_flags_only, out_zero, pair_sel, im_mode, nib_left, hl_fixed}
    function automatic logic [16:0] ref_model(input logic [7:0] o);
        logic [3:0] c  = 4'd0;
        logic [1:0] ob = 2'd0;
        logic [2:0] rg = 3'd0;
        logic fi = 1'b0, zo = 1'b0, nl = 1'b0, hf = 1'b0;
        logic [1:0] pr = 2'd0, im = 2'd0;
        logic [7:0] d;
        if (o >= 8'h40 && o <= 8'h7F) begin
            d = o - 8'h40;
            if (o inside {8'h44, 8'h4C, 8'h54, 8'h5C, 8'h64, 8'h6C, 8'h74, 8'h7C}) c = 4'd1;
            else if (o inside {8'h45, 8'h55, 8'h65, 8'h75}) c = 4'd2;
            else if (o inside {8'h4D, 8'h5D, 8'h6D, 8'h7D}) c = 4'd3;
            else if (o inside {8'h46, 8'h4E, 8'h66, 8'h6E}) c = 4'd4;
            else if (o inside {8'h56, 8'h76}) begin c = 4'd4; im = 2'd1; end
            else if (o inside {8'h5E, 8'h7E}) begin c = 4'd4; im = 2'd2; end
            else if (d % 8 == 0) begin c = 4'd5; rg = 3'(d / 8); fi = (o == 8'h70); end
            else if (d % 8 == 1) begin c = 4'd6; rg = 3'(d / 8); zo = (o == 8'h71); end
            else if (o inside {8'h42, 8'h52, 8'h62, 8'h72}) begin c = 4'd7; pr = 2'((o - 8'h42) / 16); hf = 1'b1; end
            else if (o inside {8'h4A, 8'h5A, 8'h6A, 8'h7A}) begin c = 4'd8; pr = 2'((o - 8'h4A) / 16); hf = 1'b1; end
            else if (o inside {8'h43, 8'h53, 8'h63, 8'h73}) begin c = 4'd9; ob = 2'd2; pr = 2'((o - 8'h43) / 16); end
            else if (o inside {8'h4B, 8'h5B, 8'h6B, 8'h7B}) begin c = 4'd10; ob = 2'd2; pr = 2'((o - 8'h4B) / 16); end
            else if (o inside {8'h47, 8'h4F, 8'h57, 8'h5F}) c = 4'd12;
            else if (o == 8'h67) begin c = 4'd11; hf = 1'b1; end
            else if (o == 8'h6F) begin c = 4'd11; hf = 1'b1; nl = 1'b1; end
        end else if (o inside {[8'hA0:8'hA3], [8'hA8:8'hAB], [8'hB0:8'hB3], [8'hB8:8'hBB]}) begin
            c = 4'd13;
        end
        return {c, ob, rg, fi, zo, pr, im, nl, hf};
    endfunction

    function automatic string req_of(input logic [7:0] o);
        logic [2:0] cl = o[2:0];
        if (o < 8'h40 || o >= 8'hC0) return "R1";
        if (o >= 8'h80) return "R10";
        if (cl == 3'd4) return "R2";
        if (cl == 3'd0) return "R3";
        if (cl == 3'd1) return "R4";
        if (cl == 3'd2) return "R5";
        if (cl == 3'd3) return "R6";
        if (cl == 3'd5) return "R7";
        if (cl == 3'd6) return "R8";
        return "R9";
    endfunction

    task automatic drive(input logic [7:0] o);
        item_t it;
        @(posedge clk);
        opcode <= o;
        it.op  = o;
        it.exp = ref_model(o);
        q.push_back(it);
    endtask

    // Monitor: samples on the falling edge, away from the drive edge
    always @(negedge clk) begin
        item_t       it;
        logic [16:0] act;
        if (!rst && q.size() > 0) begin
            it  = q.pop_front();
            act = {op_class, operand_bytes, port_reg, in_flags_only, out_zero,
                   pair_sel, im_mode, nib_left, hl_fixed};
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s opcode=%02h actual=%05h expected=%05h",
                         req_of(it.op), it.op, act, it.exp);
            end
        end
    end

    initial begin
        rst    = 1'b1;
        opcode = 8'h00;
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        drive(8'h00);               // R1 idle state after reset
        drive(8'h3F);               // R1 edge of the first quarter
        drive(8'hC0);               // R1 edge of the last quarter
        drive(8'h44); drive(8'h7C); // R2 first and last negate alias
        drive(8'h70); drive(8'h78); // R3 flags-only input, input to A
        drive(8'h71); drive(8'h41); // R4 zero output, output of B
        drive(8'h72); drive(8'h4A); // R5 SBC HL,SP and ADC HL,BC
        drive(8'h63); drive(8'h6B); // R6 alias stores/loads of HL
        drive(8'h4D); drive(8'h7D); drive(8'h55); // R7
        drive(8'h4E); drive(8'h56); drive(8'h7E); // R8
        drive(8'h67); drive(8'h6F); drive(8'h77); drive(8'h7F); drive(8'h5F); // R9
        drive(8'hA0); drive(8'hBB); drive(8'hA4); drive(8'h9F); drive(8'hBC); // R10
        for (int i = 0; i < 256; i++) drive(8'(i));
        repeat (3) @(posedge clk);
        if (q.size() != 0) begin
            mismatched++;
            $display("FAIL R1 queue not drained actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R1 watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule